// File: doc/BRIEF.md
# Host-Coprocessor Byte Mailbox with Run/Halt Control

This block connects an 8-bit host bus to the I/O port bus of a Z-80-style coprocessor. It passes single bytes in both directions. Each direction has a one-byte holding register and a "byte waiting" flag. The block also drives the coprocessor's active-low reset. That reset stays asserted after power-up until the host starts the coprocessor, and the host can stop the coprocessor again later.

The host sees a window of eight byte offsets. There is no read/write line on the host side, so offset bit 0 gives the direction: odd offsets are read-only and even offsets are write-only. The coprocessor side works the same way with its port address bit 0:
- a clear bit selects the data byte;
- a set bit selects the byte-available status.

Both sides share one synchronous clock, and each access is a single-cycle strobe. Read data on both sides is registered, so it is valid in the cycle after the strobe.

Top module: `hcp_mailbox`

## Requirements
- R1: After reset, `cop_reset_n` is 0 and both waiting flags are clear. A status read then returns 0x7F on either side.
- R2: A host access to offset 0 drives `cop_reset_n` to 1 from the next cycle. It stays 1 through accesses to other offsets, except offset 6.
- R3: A host access to offset 6 drives `cop_reset_n` back to 0 from the next cycle, and it stays 0 until the next access to offset 0.
- R4: A host access to offset 2 stores `host_wdata` as the inbound byte and sets the inbound flag.
- R5: A host access to offset 1 returns the outbound byte on `host_rdata` in the next cycle and clears the outbound flag.
- R6: A host access to offset 3 returns the outbound flag in bit 7, with bits 6..0 set to 1 (0x7F when empty, 0xFF when full). It changes no flag.
- R7: A coprocessor write with `cop_port0` = 0 stores `cop_wdata` as the outbound byte and sets the outbound flag. A coprocessor write with `cop_port0` = 1 changes nothing.
- R8: A coprocessor read with `cop_port0` = 0 returns the inbound byte on `cop_rdata` in the next cycle and clears the inbound flag. A read with `cop_port0` = 1 returns the inbound flag in bit 7, with bits 6..0 set to 1.
- R9: A write to a mailbox whose flag is already set replaces the byte, and the flag stays set.
- R10: If a write and a read of the same mailbox fall in the same cycle, the reader gets the old byte, the new byte is kept, and the flag stays set.
- R11: A host access to offset 4 changes nothing. Host accesses to offsets 5 and 7 return 0xFF and change no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock for both sides |
| rst | input | 1 | Synchronous active-high reset |
| host_sel | input | 1 | Single-cycle host access strobe for the window |
| host_ofs | input | 3 | Window offset; bit 0 = 1 means a read |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Registered host read data |
| cop_wr | input | 1 | Coprocessor I/O write strobe |
| cop_rd | input | 1 | Coprocessor I/O read strobe |
| cop_port0 | input | 1 | Coprocessor port address bit 0 (0 = data, 1 = status) |
| cop_wdata | input | 8 | Coprocessor write data |
| cop_rdata | output | 8 | Registered coprocessor read data |
| cop_reset_n | output | 1 | Active-low coprocessor reset |

## Verification
The functions that can collide are a writer filling a mailbox and the reader emptying that same mailbox in one cycle. This can happen in either direction. The bench provokes each case by first filling a mailbox, then driving the writer's strobe and the reader's strobe in the same clock. It judges the result by three things:
- the reader receives the byte that was held before that cycle;
- a status read afterwards still shows the flag set;
- a following data read returns the new byte.

// File: rtl/hcp_pkg.sv
package hcp_pkg;

  // Host window offsets whose values the decode depends on
  localparam int HOFS_RUN    = 0;
  localparam int HOFS_TAKE   = 1;
  localparam int HOFS_PUT    = 2;
  localparam int HOFS_PEEK   = 3;
  localparam int HOFS_HALT   = 6;

  // Decoded host operation for one strobe cycle
  typedef struct packed {
    logic run;      // release coprocessor
    logic halt;     // hold coprocessor in reset
    logic put;      // load inbound mailbox
    logic take;     // read outbound mailbox
    logic peek;     // read outbound status
    logic idle_rd;  // read of an unused odd offset
  } host_op_t;

endpackage

// File: rtl/hcp_host_decode.sv
module hcp_host_decode
  import hcp_pkg::*;
#(
  parameter int OFS_W = 3
) (
  input  logic             sel,
  input  logic [OFS_W-1:0] ofs,
  output host_op_t         op
);

  localparam logic [OFS_W-1:0] K_RUN  = OFS_W'(HOFS_RUN);
  localparam logic [OFS_W-1:0] K_TAKE = OFS_W'(HOFS_TAKE);
  localparam logic [OFS_W-1:0] K_PUT  = OFS_W'(HOFS_PUT);
  localparam logic [OFS_W-1:0] K_PEEK = OFS_W'(HOFS_PEEK);
  localparam logic [OFS_W-1:0] K_HALT = OFS_W'(HOFS_HALT);

  logic is_read;

  always_comb begin
    // offset bit 0 stands in for the missing direction line
    is_read    = ofs[0];
    op.run     = sel && (ofs == K_RUN);
    op.halt    = sel && (ofs == K_HALT);
    op.put     = sel && !is_read && (ofs == K_PUT);
    op.take    = sel && is_read && (ofs == K_TAKE);
    op.peek    = sel && is_read && (ofs == K_PEEK);
    op.idle_rd = sel && is_read && (ofs != K_TAKE) && (ofs != K_PEEK);
  end

  // R11: at most one host operation per strobe
  always_comb begin
    a_one_op_r11: assert ($countones(op) <= 1)
      else $error("host decode produced several operations");
  end

endmodule

// File: rtl/hcp_mbox_slot.sv
module hcp_mbox_slot #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr,
  input  logic [DW-1:0] wdata,
  input  logic          rd,
  output logic [DW-1:0] data,
  output logic          full
);

  always_ff @(posedge clk) begin
    if (rst) begin
      data <= '0;
      full <= 1'b0;
    end else begin
      if (wr) data <= wdata;
      // a fill in the same cycle as a drain wins
      if (wr)      full <= 1'b1;
      else if (rd) full <= 1'b0;
    end
  end

  p_fill_r9: assert property (@(posedge clk) disable iff (rst)
    wr |=> full && (data == $past(wdata)));

  p_drain_r8: assert property (@(posedge clk) disable iff (rst)
    rd && !wr |=> !full);

  p_collide_r10: assert property (@(posedge clk) disable iff (rst)
    wr && rd |=> full);

  p_hold_r11: assert property (@(posedge clk) disable iff (rst)
    !wr && !rd |=> $stable(full) && $stable(data));

endmodule

// File: rtl/hcp_reset_ctl.sv
module hcp_reset_ctl (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic halt,
  output logic cop_reset_n
);

  always_ff @(posedge clk) begin
    if (rst)       cop_reset_n <= 1'b0;
    else if (run)  cop_reset_n <= 1'b1;
    else if (halt) cop_reset_n <= 1'b0;
  end

  p_held_r1: assert property (@(posedge clk)
    rst |=> !cop_reset_n);

  p_release_r2: assert property (@(posedge clk) disable iff (rst)
    run |=> cop_reset_n);

  p_stop_r3: assert property (@(posedge clk) disable iff (rst)
    halt && !run |=> !cop_reset_n);

  p_sticky_r2: assert property (@(posedge clk) disable iff (rst)
    !run && !halt |=> $stable(cop_reset_n));

endmodule

// File: rtl/hcp_mailbox.sv
module hcp_mailbox
  import hcp_pkg::*;
#(
  parameter int DW    = 8,
  parameter int OFS_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             host_sel,
  input  logic [OFS_W-1:0] host_ofs,
  input  logic [DW-1:0]    host_wdata,
  output logic [DW-1:0]    host_rdata,
  input  logic             cop_wr,
  input  logic             cop_rd,
  input  logic             cop_port0,
  input  logic [DW-1:0]    cop_wdata,
  output logic [DW-1:0]    cop_rdata,
  output logic             cop_reset_n
);

  localparam logic [DW-2:0] FILL = {(DW-1){1'b1}};

  host_op_t       hop;
  logic           c_put, c_take, c_peek;
  logic [DW-1:0]  in_data, out_data;
  logic           in_full, out_full;

  hcp_host_decode #(.OFS_W(OFS_W)) u_dec (
    .sel (host_sel),
    .ofs (host_ofs),
    .op  (hop)
  );

  always_comb begin
    c_put  = cop_wr && !cop_port0;
    c_take = cop_rd && !cop_port0;
    c_peek = cop_rd &&  cop_port0;
  end

  // host -> coprocessor
  hcp_mbox_slot #(.DW(DW)) u_inbox (
    .clk   (clk),
    .rst   (rst),
    .wr    (hop.put),
    .wdata (host_wdata),
    .rd    (c_take),
    .data  (in_data),
    .full  (in_full)
  );

  // coprocessor -> host
  hcp_mbox_slot #(.DW(DW)) u_outbox (
    .clk   (clk),
    .rst   (rst),
    .wr    (c_put),
    .wdata (cop_wdata),
    .rd    (hop.take),
    .data  (out_data),
    .full  (out_full)
  );

  hcp_reset_ctl u_rst (
    .clk         (clk),
    .rst         (rst),
    .run         (hop.run),
    .halt        (hop.halt),
    .cop_reset_n (cop_reset_n)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      host_rdata <= '0;
    end else if (hop.take) begin
      host_rdata <= out_data;
    end else if (hop.peek) begin
      host_rdata <= {out_full, FILL};
    end else if (hop.idle_rd) begin
      host_rdata <= '1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cop_rdata <= '0;
    end else if (c_take) begin
      cop_rdata <= in_data;
    end else if (c_peek) begin
      cop_rdata <= {in_full, FILL};
    end
  end

  p_host_status_r6: assert property (@(posedge clk) disable iff (rst)
    hop.peek |=> (host_rdata[DW-1] == $past(out_full)) && (host_rdata[DW-2:0] == FILL));

  p_host_take_r5: assert property (@(posedge clk) disable iff (rst)
    hop.take |=> (host_rdata == $past(out_data)) && !out_full || $past(c_put));

  p_cop_take_r8: assert property (@(posedge clk) disable iff (rst)
    c_take |=> cop_rdata == $past(in_data));

  p_unused_r11: assert property (@(posedge clk) disable iff (rst)
    hop.idle_rd |=> host_rdata == '1);

  p_odd_write_r7: assert property (@(posedge clk) disable iff (rst)
    cop_wr && cop_port0 && !hop.take |=> $stable(out_full) && $stable(out_data));

endmodule

// File: tb/hcp_mailbox_test.sv
module hcp_mailbox_test;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       host_sel = 1'b0;
  logic [2:0] host_ofs = '0;
  logic [7:0] host_wdata = '0;
  logic [7:0] host_rdata;
  logic       cop_wr = 1'b0;
  logic       cop_rd = 1'b0;
  logic       cop_port0 = 1'b0;
  logic [7:0] cop_wdata = '0;
  logic [7:0] cop_rdata;
  logic       cop_reset_n;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hcp_mailbox uut (
    .clk(clk), .rst(rst),
    .host_sel(host_sel), .host_ofs(host_ofs), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .cop_wr(cop_wr), .cop_rd(cop_rd), .cop_port0(cop_port0), .cop_wdata(cop_wdata),
    .cop_rdata(cop_rdata), .cop_reset_n(cop_reset_n)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // one clock with the given strobes, returns at the following falling edge
  task automatic step(input logic hs, input logic [2:0] ho, input logic [7:0] hw,
                      input logic cw, input logic cr, input logic cp, input logic [7:0] cd);
    host_sel = hs; host_ofs = ho; host_wdata = hw;
    cop_wr = cw; cop_rd = cr; cop_port0 = cp; cop_wdata = cd;
    @(posedge clk);
    @(negedge clk);
    host_sel = 1'b0; cop_wr = 1'b0; cop_rd = 1'b0;
  endtask

  task automatic hacc(input logic [2:0] o, input logic [7:0] d);
    step(1'b1, o, d, 1'b0, 1'b0, 1'b0, 8'h00);
  endtask

  task automatic cwrite(input logic p, input logic [7:0] d);
    step(1'b0, 3'd0, 8'h00, 1'b1, 1'b0, p, d);
  endtask

  task automatic cread(input logic p);
    step(1'b0, 3'd0, 8'h00, 1'b0, 1'b1, p, 8'h00);
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog R1 act=%0h exp=%0h", 0, 1);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk("R1 reset held", int'(cop_reset_n), 0);
    hacc(3'd3, 8'h00);
    chk("R1 host status empty", int'(host_rdata), 8'h7F);
    cread(1'b1);
    chk("R1 cop status empty", int'(cop_rdata), 8'h7F);

    // R3 halt while held, R2 start
    hacc(3'd6, 8'h00);
    chk("R3 halt keeps reset", int'(cop_reset_n), 0);
    hacc(3'd0, 8'h5C);
    chk("R2 start releases", int'(cop_reset_n), 1);
    for (int o = 1; o < 8; o++) begin
      if (o == 6) continue;
      hacc(3'(o), 8'hA5);
      chk("R2 release sticky", int'(cop_reset_n), 1);
    end
    hacc(3'd6, 8'h00);
    chk("R3 halt asserts", int'(cop_reset_n), 0);
    hacc(3'd5, 8'h00);
    chk("R3 halt sticky", int'(cop_reset_n), 0);
    hacc(3'd1, 8'h00);   // read access to offset 0 is impossible; odd offset keeps held
    chk("R3 halt sticky odd", int'(cop_reset_n), 0);
    hacc(3'd0, 8'h00);
    chk("R2 restart", int'(cop_reset_n), 1);

    // sweep every byte in both directions
    for (int v = 0; v < 256; v++) begin
      hacc(3'd2, 8'(v));
      cread(1'b1);
      chk("R4 inbound flag set", int'(cop_rdata), 8'hFF);
      hacc(3'd3, 8'h00);
      chk("R6 outbound status idle", int'(host_rdata), 8'h7F);
      cread(1'b0);
      chk("R8 inbound data", int'(cop_rdata), v);
      cread(1'b1);
      chk("R8 inbound flag cleared", int'(cop_rdata), 8'h7F);

      cwrite(1'b0, 8'(v ^ 8'h5A));
      hacc(3'd3, 8'h00);
      chk("R7 outbound flag set", int'(host_rdata), 8'hFF);
      hacc(3'd3, 8'h00);
      chk("R6 status read keeps flag", int'(host_rdata), 8'hFF);
      hacc(3'd1, 8'h00);
      chk("R5 outbound data", int'(host_rdata), v ^ 8'h5A);
      hacc(3'd3, 8'h00);
      chk("R5 outbound flag cleared", int'(host_rdata), 8'h7F);
    end

    // R7 odd-port write ignored: last outbound byte was 0xFF^0x5A
    cwrite(1'b1, 8'h33);
    hacc(3'd3, 8'h00);
    chk("R7 odd write no flag", int'(host_rdata), 8'h7F);
    hacc(3'd1, 8'h00);
    chk("R7 odd write no data", int'(host_rdata), 8'hA5);

    // R9 overwrite
    hacc(3'd2, 8'h11);
    hacc(3'd2, 8'h22);
    cread(1'b1);
    chk("R9 inbound still full", int'(cop_rdata), 8'hFF);
    cread(1'b0);
    chk("R9 inbound newest", int'(cop_rdata), 8'h22);
    cwrite(1'b0, 8'h44);
    cwrite(1'b0, 8'h55);
    hacc(3'd3, 8'h00);
    chk("R9 outbound still full", int'(host_rdata), 8'hFF);
    hacc(3'd1, 8'h00);
    chk("R9 outbound newest", int'(host_rdata), 8'h55);

    // R10 collisions
    hacc(3'd2, 8'h66);
    step(1'b1, 3'd2, 8'h77, 1'b0, 1'b1, 1'b0, 8'h00);
    chk("R10 inbound reader old", int'(cop_rdata), 8'h66);
    cread(1'b1);
    chk("R10 inbound flag kept", int'(cop_rdata), 8'hFF);
    cread(1'b0);
    chk("R10 inbound new kept", int'(cop_rdata), 8'h77);
    cwrite(1'b0, 8'h88);
    step(1'b1, 3'd1, 8'h00, 1'b1, 1'b0, 1'b0, 8'h99);
    chk("R10 outbound reader old", int'(host_rdata), 8'h88);
    hacc(3'd3, 8'h00);
    chk("R10 outbound flag kept", int'(host_rdata), 8'hFF);
    hacc(3'd1, 8'h00);
    chk("R10 outbound new kept", int'(host_rdata), 8'h99);

    // R11 unused offsets
    cwrite(1'b0, 8'h12);
    hacc(3'd4, 8'hAB);
    cread(1'b1);
    chk("R11 offset 4 no inbound", int'(cop_rdata), 8'h7F);
    chk("R11 offset 4 no reset change", int'(cop_reset_n), 1);
    hacc(3'd5, 8'h00);
    chk("R11 offset 5 reads ones", int'(host_rdata), 8'hFF);
    hacc(3'd7, 8'h00);
    chk("R11 offset 7 reads ones", int'(host_rdata), 8'hFF);
    hacc(3'd3, 8'h00);
    chk("R11 outbound flag kept", int'(host_rdata), 8'hFF);
    hacc(3'd1, 8'h00);
    chk("R11 outbound data kept", int'(host_rdata), 8'h12);

    finish_run();
  end

endmodule